// File: doc/BRIEF.md
# Pointer Authentication Checker

This block takes a signed 64-bit pointer and hands back its canonical form. On every request it clears the authentication code out of the pointer. The code sits between a caller-supplied lowest code bit and the top of the address field. The block refills that span with copies of the range-select bit, which is always pointer bit 55. The top of the span is bit 55 when the tag-ignore decision is set and bit 63 when it is not.

In authenticate mode the canonical pointer goes to an external cipher engine over a valid/ready request channel, together with the modifier and the key class. The engine returns a 64-bit code on a response strobe. The block compares the returned code with the code bits that were embedded in the pointer. On a match it outputs the canonical pointer. On a mismatch it outputs a poisoned pointer that carries a 2-bit error code in high address bits.

In strip-only mode the block only canonicalises the pointer. It sends no cipher request and makes no comparison. The result appears together with a one-bit pass flag. Only one request is in flight at a time.

Top module: `pac_checker`

## Requirements
- R1: `inReady` is high only when the block is idle. While a request is in flight, `inValid` and all request inputs are ignored, and the pending result is unaffected.
- R2: With tag-ignore set, the canonical pointer has bits `inBotBit`..55 equal to pointer bit 55. All other bits, including 63:56, are unchanged.
- R3: With tag-ignore clear, the canonical pointer has bits `inBotBit`..63 equal to pointer bit 55. Bits below `inBotBit` are unchanged.
- R4: In authenticate mode, `cipherReqValid` rises in the cycle after acceptance and carries the canonical pointer, the modifier and the key class. It holds with stable data until `cipherReqReady`, and it drops after the handshake; only one request is outstanding.
- R5: With tag-ignore set, a match needs only bits 54..`inBotBit` of the returned code to equal the same pointer bits. Bits 63:56 are not compared. On a match `outResult` is exactly the canonical pointer and `outPass` is 1.
- R6: With tag-ignore clear, a match also needs code bits 63:56 to equal pointer bits 63:56.
- R7: On a mismatch with tag-ignore set, `outResult` is the canonical pointer with bits 54:53 replaced by the error code, and `outPass` is 0.
- R8: On a mismatch with tag-ignore clear, `outResult` is the canonical pointer with bits 62:61 replaced by the error code, and `outPass` is 0.
- R9: The error code is 2'b01 for the A key class (`inKeyB`=0) and 2'b10 for the B key class (`inKeyB`=1).
- R10: In strip-only mode (`inStrip`=1), `outValid` is high in the cycle after acceptance, with the canonical pointer and `outPass`=1, and no cipher request is raised.
- R11: After reset, `inReady` is 1 and `outValid` and `cipherReqValid` are 0. `outValid` is a single-cycle pulse per request, one cycle after the cipher response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Block idle, request accepted |
| inPtr | input | 64 | Signed pointer |
| inMod | input | 64 | Modifier |
| inTagIgnore | input | 1 | Top byte is a tag, excluded from the code field |
| inBotBit | input | 6 | Lowest code bit position |
| inKeyB | input | 1 | Key class: 0 = A, 1 = B |
| inStrip | input | 1 | Strip-only mode |
| cipherReqValid | output | 1 | Cipher request valid |
| cipherReqReady | input | 1 | Cipher engine accepts request |
| cipherReqPtr | output | 64 | Canonical pointer to cipher |
| cipherReqMod | output | 64 | Modifier to cipher |
| cipherReqKeyB | output | 1 | Key class to cipher |
| cipherRspValid | input | 1 | Cipher response strobe |
| cipherRspCode | input | 64 | Recomputed code |
| outValid | output | 1 | Result pulse |
| outResult | output | 64 | Restored or poisoned pointer |
| outPass | output | 1 | 1 = authenticated or stripped, 0 = poisoned |

## Verification
The hardest case to reach is a mismatch with tag-ignore set in which only the top byte of the returned code differs. It must still pass. The mirror case is a pointer whose code bits agree but whose top byte disagrees with tag-ignore clear, which must be poisoned at bits 62:61. The bench plays the cipher engine itself and builds response codes from the pointer, so it can flip exactly one chosen bit field in each run. The bench also stalls the request handshake for several cycles while it drives new, different requests at the input, to show that they are ignored.

// File: rtl/pac_chk_pkg.sv
package pac_chk_pkg;
  localparam int PTR_W        = 64;
  localparam int BOT_W        = $clog2(PTR_W);
  localparam int SEL_BIT      = 55;
  localparam int TAG_LO       = SEL_BIT + 1;
  localparam int ERR_TAG_LO   = 53;
  localparam int ERR_NOTAG_LO = 61;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_DONE} chkState_t;

  typedef struct packed {
    logic load;
    logic capCode;
  } ctlStrobe_t;
endpackage

// File: rtl/pac_chk_dp.sv
module pac_chk_dp
  import pac_chk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [PTR_W-1:0]   inPtr,
  input  logic [PTR_W-1:0]   inMod,
  input  logic               inTagIgnore,
  input  logic [BOT_W-1:0]   inBotBit,
  input  logic               inKeyB,
  input  logic               inStrip,
  input  logic [PTR_W-1:0]   rspCode,
  output logic [PTR_W-1:0]   reqPtr,
  output logic [PTR_W-1:0]   reqMod,
  output logic               reqKeyB,
  output logic [PTR_W-1:0]   result,
  output logic               pass
);
  logic [PTR_W-1:0] ptrQ, modQ, codeQ;
  logic             tbiQ, keyBQ, stripQ;
  logic [BOT_W-1:0] botQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0; modQ <= '0; codeQ <= '0;
      tbiQ <= 1'b0; keyBQ <= 1'b0; stripQ <= 1'b0; botQ <= '0;
    end else begin
      if (strobe.load) begin
        ptrQ   <= inPtr;
        modQ   <= inMod;
        tbiQ   <= inTagIgnore;
        botQ   <= inBotBit;
        keyBQ  <= inKeyB;
        stripQ <= inStrip;
      end
      if (strobe.capCode) codeQ <= rspCode;
    end
  end

  logic [PTR_W-1:0] fieldMask, cmpMask;

  for (genvar gi = 0; gi < PTR_W; gi++) begin : g_bit
    localparam logic [BOT_W:0] POS = (BOT_W+1)'(gi);
    logic aboveBot;
    assign aboveBot = ({1'b0, botQ} <= POS);
    if (gi < SEL_BIT) begin : g_code
      assign fieldMask[gi] = aboveBot;
      assign cmpMask[gi]   = aboveBot;
    end else if (gi == SEL_BIT) begin : g_sel
      assign fieldMask[gi] = aboveBot;
      assign cmpMask[gi]   = 1'b0;
    end else begin : g_tag
      assign fieldMask[gi] = aboveBot && !tbiQ;
      assign cmpMask[gi]   = !tbiQ;
    end
  end

  logic [PTR_W-1:0] canon, poisoned;
  logic [1:0]       errCode;
  logic             match;

  assign canon   = (ptrQ & ~fieldMask) | (fieldMask & {PTR_W{ptrQ[SEL_BIT]}});
  assign errCode = keyBQ ? 2'b10 : 2'b01;
  assign match   = (((codeQ ^ ptrQ) & cmpMask) == '0);

  always_comb begin
    poisoned = canon;
    if (tbiQ) poisoned[ERR_TAG_LO +: 2]   = errCode;
    else      poisoned[ERR_NOTAG_LO +: 2] = errCode;
  end

  assign pass    = stripQ || match;
  assign result  = pass ? canon : poisoned;
  assign reqPtr  = canon;
  assign reqMod  = modQ;
  assign reqKeyB = keyBQ;

  // R9
  err_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pass |-> ((tbiQ ? result[ERR_TAG_LO +: 2] : result[ERR_NOTAG_LO +: 2])
               == (keyBQ ? 2'b10 : 2'b01)));

  // R5
  tag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    tbiQ |-> (result[PTR_W-1:TAG_LO] == ptrQ[PTR_W-1:TAG_LO]));
endmodule

// File: rtl/pac_chk_ctl.sv
module pac_chk_ctl
  import pac_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inStrip,
  output logic       inReady,
  output logic       cipherReqValid,
  input  logic       cipherReqReady,
  input  logic       cipherRspValid,
  output logic       outValid,
  output ctlStrobe_t strobe
);
  chkState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (inValid) stateNxt = inStrip ? ST_DONE : ST_SEND;
      ST_SEND: if (cipherReqReady) stateNxt = ST_WAIT;
      ST_WAIT: if (cipherRspValid) stateNxt = ST_DONE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign inReady        = (state == ST_IDLE);
  assign cipherReqValid = (state == ST_SEND);
  assign outValid       = (state == ST_DONE);
  assign strobe.load    = (state == ST_IDLE) && inValid;
  assign strobe.capCode = (state == ST_WAIT) && cipherRspValid;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cipherReqValid && !cipherReqReady |=> cipherReqValid);

  // R10
  strip_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && inStrip |=> outValid && !cipherReqValid);

  // R1
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cipherReqValid || outValid) |-> !inReady);

  // R11
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid && inReady);
endmodule

// File: rtl/pac_checker.sv
module pac_checker
  import pac_chk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [PTR_W-1:0]   inPtr,
  input  logic [PTR_W-1:0]   inMod,
  input  logic               inTagIgnore,
  input  logic [BOT_W-1:0]   inBotBit,
  input  logic               inKeyB,
  input  logic               inStrip,
  output logic               cipherReqValid,
  input  logic               cipherReqReady,
  output logic [PTR_W-1:0]   cipherReqPtr,
  output logic [PTR_W-1:0]   cipherReqMod,
  output logic               cipherReqKeyB,
  input  logic               cipherRspValid,
  input  logic [PTR_W-1:0]   cipherRspCode,
  output logic               outValid,
  output logic [PTR_W-1:0]   outResult,
  output logic               outPass
);
  ctlStrobe_t strobe;

  pac_chk_ctl i_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStrip(inStrip),
    .inReady(inReady), .cipherReqValid(cipherReqValid),
    .cipherReqReady(cipherReqReady), .cipherRspValid(cipherRspValid),
    .outValid(outValid), .strobe(strobe)
  );

  pac_chk_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inPtr(inPtr), .inMod(inMod),
    .inTagIgnore(inTagIgnore), .inBotBit(inBotBit), .inKeyB(inKeyB),
    .inStrip(inStrip), .rspCode(cipherRspCode), .reqPtr(cipherReqPtr),
    .reqMod(cipherReqMod), .reqKeyB(cipherReqKeyB), .result(outResult),
    .pass(outPass)
  );
endmodule

// File: tb/test_pac_checker.sv
module test_pac_checker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inReady;
  logic [63:0] inPtr = '0, inMod = '0;
  logic        inTagIgnore = 1'b0, inKeyB = 1'b0, inStrip = 1'b0;
  logic [5:0]  inBotBit = '0;
  logic        cipherReqValid, cipherReqReady = 1'b0, cipherReqKeyB;
  logic [63:0] cipherReqPtr, cipherReqMod;
  logic        cipherRspValid = 1'b0;
  logic [63:0] cipherRspCode = '0;
  logic        outValid, outPass;
  logic [63:0] outResult;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pac_checker i_pac_checker (.*);

  function automatic logic [63:0] canon(logic [63:0] p, logic t, logic [5:0] b);
    logic [63:0] r = p;
    for (int i = 0; i < 64; i++)
      if (i >= int'(b) && (i <= 55 || !t)) r[i] = p[55];
    return r;
  endfunction

  function automatic logic expMatch(logic [63:0] p, logic [63:0] c, logic t, logic [5:0] b);
    logic m = 1'b1;
    for (int i = 0; i < 55; i++) if (i >= int'(b) && c[i] != p[i]) m = 1'b0;
    if (!t && c[63:56] != p[63:56]) m = 1'b0;
    return m;
  endfunction

  function automatic logic [63:0] expRes(logic [63:0] p, logic [63:0] c, logic t,
                                         logic [5:0] b, logic kb);
    logic [63:0] r = canon(p, t, b);
    logic [1:0]  e = kb ? 2'b10 : 2'b01;
    if (!expMatch(p, c, t, b)) begin
      if (t) r[54:53] = e; else r[62:61] = e;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic runAuth(string rq, logic [63:0] p, logic [63:0] m, logic t,
                         logic [5:0] b, logic kb, logic [63:0] code,
                         int rdyDelay, logic pokeBusy);
    @(negedge clk);
    inPtr = p; inMod = m; inTagIgnore = t; inBotBit = b; inKeyB = kb;
    inStrip = 1'b0; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R4 reqValid", 64'(cipherReqValid), 64'd1);
    chk(t ? "R2 reqPtr" : "R3 reqPtr", cipherReqPtr, canon(p, t, b));
    chk("R4 reqMod", cipherReqMod, m);
    chk("R4 reqKey", 64'(cipherReqKeyB), 64'(kb));
    if (pokeBusy) begin
      inValid = 1'b1; inPtr = ~p; inTagIgnore = ~t; inKeyB = ~kb; inStrip = 1'b1;
    end
    for (int k = 0; k < rdyDelay; k++) begin
      @(negedge clk);
      chk("R4 hold", 64'(cipherReqValid), 64'd1);
      chk("R4 stable", cipherReqPtr, canon(p, t, b));
      chk("R1 busy", 64'(inReady), 64'd0);
    end
    cipherReqReady = 1'b1;
    @(negedge clk);
    cipherReqReady = 1'b0;
    chk("R4 drop", 64'(cipherReqValid), 64'd0);
    chk("R11 noEarlyOut", 64'(outValid), 64'd0);
    if (pokeBusy) chk("R1 busyWait", 64'(inReady), 64'd0);
    cipherRspValid = 1'b1; cipherRspCode = code;
    @(negedge clk);
    cipherRspValid = 1'b0;
    inValid = 1'b0; inStrip = 1'b0;
    chk("R11 outValid", 64'(outValid), 64'd1);
    chk(rq, outResult, expRes(p, code, t, b, kb));
    chk(rq, 64'(outPass), 64'(expMatch(p, code, t, b)));
    @(negedge clk);
    chk("R11 pulse", 64'(outValid), 64'd0);
    chk("R1 idle", 64'(inReady), 64'd1);
  endtask

  task automatic runStrip(logic [63:0] p, logic t, logic [5:0] b);
    @(negedge clk);
    inPtr = p; inTagIgnore = t; inBotBit = b; inStrip = 1'b1; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; inStrip = 1'b0;
    chk("R10 outValid", 64'(outValid), 64'd1);
    chk("R10 noReq", 64'(cipherReqValid), 64'd0);
    chk("R10 result", outResult, canon(p, t, b));
    chk("R10 pass", 64'(outPass), 64'd1);
    @(negedge clk);
    chk("R10 noReqAfter", 64'(cipherReqValid), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] p;
    repeat (3) @(negedge clk);
    chk("R11 rstReady", 64'(inReady), 64'd1);
    chk("R11 rstOut", 64'(outValid), 64'd0);
    chk("R11 rstReq", 64'(cipherReqValid), 64'd0);
    rstN = 1'b1;

    // R5 pass with tag ignore, key A, top byte differs
    p = 64'h5A3A_5555_0000_1234;
    runAuth("R5", p, 64'h1111, 1'b1, 6'd48, 1'b0, {8'hC3, p[55:0]}, 0, 1'b0);
    // R7 R9 tag ignore mismatch, key B
    runAuth("R7", p, 64'h2222, 1'b1, 6'd48, 1'b1, p ^ 64'h0004_0000_0000_0000, 2, 1'b0);
    // R7 R9 key A, pointer in upper range
    p = 64'h7F80_1234_5678_9ABC;
    runAuth("R9", p, 64'h3333, 1'b1, 6'd40, 1'b0, p ^ 64'h0000_0100_0000_0000, 1, 1'b0);
    // R6 pass without tag ignore, delayed ready, busy pokes ignored
    p = 64'hA5C3_00FF_EEDD_CCBB;
    runAuth("R6", p, 64'h4444, 1'b0, 6'd40, 1'b0, p, 3, 1'b1);
    // R8 R6 mismatch only in top byte, key A
    runAuth("R8", p, 64'h5555, 1'b0, 6'd40, 1'b0, p ^ 64'h0100_0000_0000_0000, 0, 1'b0);
    // R8 R9 upper range, key B
    p = 64'h0E9C_4321_0000_FFFF;
    runAuth("R9", p, 64'h6666, 1'b0, 6'd48, 1'b1, p ^ 64'h0001_0000_0000_0000, 0, 1'b1);
    // R10 strip both tag settings
    runStrip(64'hDEAD_BEEF_0123_4567, 1'b1, 6'd48);
    runStrip(64'h1280_0000_0000_0042, 1'b0, 6'd36);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule